// File: doc/BRIEF.md
# Cascadable Synchronous Up/Down Counter Stage

This block is one stage of a synchronous binary counter that can be preset and can count in either direction. Every bit of the count register changes on the same rising clock edge, so the outputs never ripple. A low level on the active-low preset input copies a parallel data word into the count on the next edge, and it takes priority over counting. The count steps by one only when both active-low enables are low. A direction input picks increment (high) or decrement (low), and the count wraps at both ends.

The active-low terminal-count output goes low only while the chain enable is low and the count sits at the end of its range for the current direction: all ones when counting up, zero when counting down. It is decoded directly from the chain enable, the direction and the count. It is fed straight to the chain enable of the next stage up, so several stages make one wide synchronous counter with no extra gating. The count enable has no effect on this output. In a chain, the count enable and the preset go to every stage. The lowest stage's chain enable is the global enable.

Control inputs may change at any clock level and act only at the next rising edge. The one exception is the terminal-count output, which follows its inputs without waiting for an edge. The data path has no stream interface: the count is always valid, nothing is handed over, and no back-pressure exists, so every pin is a plain level.

Top module: `updn_stage`

## Requirements
- R1: While the active-high synchronous reset `rst` is high at a rising edge, the count becomes 0 on that edge.
- R2: When `preset_n` is low at a rising edge, `count` takes `pdata` on that edge, whatever the enables and direction are.
- R3: When `preset_n` is high and both `cnt_ena_n` and `chain_ena_n` are low at a rising edge, `count` changes by exactly one on that edge.
- R4: The step is +1 when `dir_up` is 1 and -1 when `dir_up` is 0, sampled at that edge.
- R5: When `preset_n` is high and either `cnt_ena_n` or `chain_ena_n` is high at a rising edge, `count` keeps its value.
- R6: `tc_n` is 0 exactly when `chain_ena_n` is 0 and `count` is all ones with `dir_up`=1, or zero with `dir_up`=0; `cnt_ena_n` does not affect `tc_n`.
- R7: `tc_n` is combinational: at count 0 or all ones it follows a change of `dir_up` or `chain_ena_n` with no clock edge.
- R8: The count wraps from all ones to 0 going up, and from 0 to all ones going down.
- R9: Stages chained with each stage's `tc_n` driving the next stage's `chain_ena_n`, and with shared `preset_n`, `cnt_ena_n` and `dir_up`, act as one wider binary up/down counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Active-high synchronous clear, for initialisation |
| preset_n | input | 1 | Active-low synchronous parallel load |
| cnt_ena_n | input | 1 | Active-low count enable; does not gate the carry |
| chain_ena_n | input | 1 | Active-low count enable that also enables `tc_n` |
| dir_up | input | 1 | 1 = count up, 0 = count down |
| pdata | input | WIDTH | Parallel preset value |
| count | output | WIDTH | Current count |
| tc_n | output | 1 | Active-low terminal-count carry to the next stage |

## Verification
A wrong toggle condition on any bit shows at `count` on the very next edge. Most such faults only appear when the lower bits reach all ones or all zeros, so the bench drives the count through those boundaries in both directions. A wrong terminal decode shows at once at `tc_n`, with no clock needed. In a chain it also corrupts the upper stage's count on the following edge. Checking a three-stage chain therefore turns a carry fault into a count error within one cycle. A preset that loses its priority shows as a count one step off the loaded value on the edge that should have loaded.

// File: rtl/updn_pkg.sv
package updn_pkg;
  // What the register does on the coming edge
  typedef enum logic [1:0] {
    OP_HOLD = 2'd0,
    OP_LOAD = 2'd1,
    OP_STEP = 2'd2
  } op_e;
endpackage

// File: rtl/updn_ctrl.sv
module updn_ctrl
  import updn_pkg::*;
(
  input  logic rst,
  input  logic preset_n,
  input  logic cnt_ena_n,
  input  logic chain_ena_n,
  output op_e  op,
  output logic clear
);
  // Priority: clear, then preset, then step, else hold
  always_comb begin
    clear = rst;
    if (!preset_n)                       op = OP_LOAD;
    else if (!cnt_ena_n && !chain_ena_n) op = OP_STEP;
    else                                 op = OP_HOLD;
  end
endmodule

// File: rtl/updn_next.sv
module updn_next
  import updn_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  op_e              op,
  input  logic             dir_up,
  input  logic [WIDTH-1:0] count,
  input  logic [WIDTH-1:0] pdata,
  output logic [WIDTH-1:0] nxt
);
  // Look-ahead toggle chain: bit i flips when every lower bit already
  // sits at the value that rolls over in the chosen direction.
  logic [WIDTH:0]   tog;
  logic [WIDTH-1:0] stepped;

  assign tog[0] = 1'b1;

  genvar i;
  generate
    for (i = 0; i < WIDTH; i++) begin : g_bit
      logic at_roll;
      assign at_roll    = dir_up ? count[i] : ~count[i];
      assign tog[i+1]   = tog[i] & at_roll;
      assign stepped[i] = count[i] ^ tog[i];
    end
  endgenerate

  always_comb begin
    unique case (op)
      OP_LOAD: nxt = pdata;
      OP_STEP: nxt = stepped;
      default: nxt = count;
    endcase
  end
endmodule

// File: rtl/updn_term.sv
module updn_term #(
  parameter int WIDTH = 4
) (
  input  logic             chain_ena_n,
  input  logic             dir_up,
  input  logic [WIDTH-1:0] count,
  output logic             tc_n
);
  // End of range for the current direction: every bit equals dir_up
  logic [WIDTH-1:0] bit_end;
  logic             at_end;

  genvar i;
  generate
    for (i = 0; i < WIDTH; i++) begin : g_end
      assign bit_end[i] = ~(count[i] ^ dir_up);
    end
  endgenerate

  assign at_end = &bit_end;
  assign tc_n   = ~(at_end & ~chain_ena_n);
endmodule

// File: rtl/updn_stage.sv
module updn_stage
  import updn_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             preset_n,
  input  logic             cnt_ena_n,
  input  logic             chain_ena_n,
  input  logic             dir_up,
  input  logic [WIDTH-1:0] pdata,
  output logic [WIDTH-1:0] count,
  output logic             tc_n
);
  localparam logic [WIDTH-1:0] ALL_ONES = {WIDTH{1'b1}};
  localparam logic [WIDTH-1:0] ONE      = WIDTH'(1);

  op_e              op;
  logic             clear;
  logic [WIDTH-1:0] nxt;
  logic [WIDTH-1:0] cnt_q;

  updn_ctrl u_ctrl (
    .rst         (rst),
    .preset_n    (preset_n),
    .cnt_ena_n   (cnt_ena_n),
    .chain_ena_n (chain_ena_n),
    .op          (op),
    .clear       (clear)
  );

  updn_next #(.WIDTH(WIDTH)) u_next (
    .op     (op),
    .dir_up (dir_up),
    .count  (cnt_q),
    .pdata  (pdata),
    .nxt    (nxt)
  );

  always_ff @(posedge clk) begin
    if (clear) cnt_q <= '0;
    else       cnt_q <= nxt;
  end

  updn_term #(.WIDTH(WIDTH)) u_term (
    .chain_ena_n (chain_ena_n),
    .dir_up      (dir_up),
    .count       (cnt_q),
    .tc_n        (tc_n)
  );

  assign count = cnt_q;

  // Assertions guarding the register and its carry decode
  p_clear_r1: assert property (@(posedge clk) rst |=> count == '0);

  p_load_r2: assert property (@(posedge clk) disable iff (rst)
    !preset_n |=> count == $past(pdata));

  p_up_r4: assert property (@(posedge clk) disable iff (rst)
    (preset_n && !cnt_ena_n && !chain_ena_n && dir_up)
      |=> count == WIDTH'($past(count) + ONE));

  p_down_r4: assert property (@(posedge clk) disable iff (rst)
    (preset_n && !cnt_ena_n && !chain_ena_n && !dir_up)
      |=> count == WIDTH'($past(count) - ONE));

  p_hold_r5: assert property (@(posedge clk) disable iff (rst)
    (preset_n && (cnt_ena_n || chain_ena_n)) |=> $stable(count));

  p_wrap_r8: assert property (@(posedge clk) disable iff (rst)
    (preset_n && !cnt_ena_n && !chain_ena_n && dir_up && count == ALL_ONES)
      |=> count == '0);

  p_tc_end_r6: assert property (@(posedge clk) disable iff (rst)
    (!chain_ena_n && ((dir_up && count == ALL_ONES) || (!dir_up && count == '0)))
      |-> !tc_n);

  p_tc_idle_r6: assert property (@(posedge clk) disable iff (rst)
    chain_ena_n |-> tc_n);
endmodule

// File: tb/sim_updn_stage.sv
module sim_updn_stage;
  localparam int W  = 4;
  localparam int NS = 3;
  localparam int CW = W * NS;

  typedef struct {
    logic [CW-1:0] val;
    string         tag;
  } exp_t;

  logic clk = 1'b0;
  logic rst;
  logic preset_n, cnt_ena_n, ent_n, dir_up;
  logic [CW-1:0] pdata;
  logic [CW-1:0] q;
  logic [NS-1:0] tcn;

  int n_cmp = 0;
  int n_bad = 0;
  exp_t sb[$];
  logic [CW-1:0] model;

  always #2 clk = ~clk;

  updn_stage #(.WIDTH(W)) u0 (
    .clk(clk), .rst(rst), .preset_n(preset_n), .cnt_ena_n(cnt_ena_n),
    .chain_ena_n(ent_n), .dir_up(dir_up), .pdata(pdata[W-1:0]),
    .count(q[W-1:0]), .tc_n(tcn[0]));
  updn_stage #(.WIDTH(W)) u1 (
    .clk(clk), .rst(rst), .preset_n(preset_n), .cnt_ena_n(cnt_ena_n),
    .chain_ena_n(tcn[0]), .dir_up(dir_up), .pdata(pdata[2*W-1:W]),
    .count(q[2*W-1:W]), .tc_n(tcn[1]));
  updn_stage #(.WIDTH(W)) u2 (
    .clk(clk), .rst(rst), .preset_n(preset_n), .cnt_ena_n(cnt_ena_n),
    .chain_ena_n(tcn[1]), .dir_up(dir_up), .pdata(pdata[3*W-1:2*W]),
    .count(q[3*W-1:2*W]), .tc_n(tcn[2]));

  // Driver: apply one cycle of inputs at the falling edge, check the
  // combinational carry, and push the expected count for the next edge.
  task automatic step(input bit r, input bit ld, input logic [CW-1:0] d,
                      input bit p, input bit t, input bit u, input string tag);
    exp_t e;
    logic exp_tc;
    @(negedge clk);
    rst = r; preset_n = ld; pdata = d; cnt_ena_n = p; ent_n = t; dir_up = u;
    #1;
    if (!r) begin
      exp_tc = !(!t && (u ? (model == {CW{1'b1}}) : (model == '0)));
      n_cmp++;
      if (tcn[NS-1] !== exp_tc) begin
        n_bad++;
        $display("FAIL R6/R7 carry (%s): got %b expected %b", tag, tcn[NS-1], exp_tc);
      end
    end
    if (r)             model = '0;
    else if (!ld)      model = d;
    else if (!p && !t) model = u ? model + 1'b1 : model - 1'b1;
    e.val = model; e.tag = tag;
    sb.push_back(e);
  endtask

  // Monitor: one expected entry per rising edge
  always @(posedge clk) begin
    #1;
    if (sb.size() > 0) begin
      exp_t e;
      e = sb.pop_front();
      n_cmp++;
      if (q !== e.val) begin
        n_bad++;
        $display("FAIL %s count: got %h expected %h", e.tag, q, e.val);
      end
    end
  end

  initial begin
    #(4 * 20000);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    model = '0;
    rst = 1'b1; preset_n = 1'b1; cnt_ena_n = 1'b1; ent_n = 1'b1;
    dir_up = 1'b1; pdata = '0;
    step(1, 1, 12'h5A5, 0, 0, 1, "R1 reset");
    step(1, 0, 12'h5A5, 0, 0, 1, "R1 reset over load");
    // R3 R4 count up from zero
    for (int i = 0; i < 20; i++) step(0, 1, '0, 0, 0, 1, "R3 R4 up");
    // R5 hold with either enable high
    for (int i = 0; i < 4; i++) step(0, 1, '0, 1, 0, 1, "R5 hold enp");
    for (int i = 0; i < 4; i++) step(0, 1, '0, 0, 1, 0, "R5 hold ent");
    // R2 load overrides counting
    step(0, 0, 12'hFFD, 0, 0, 1, "R2 load");
    // R8 wrap upward across full range
    for (int i = 0; i < 5; i++) step(0, 1, '0, 0, 0, 1, "R8 R9 up wrap");
    // R9 carry from stage 0 into stage 1 and 1 into 2
    step(0, 0, 12'h0FC, 1, 1, 1, "R2 load held");
    for (int i = 0; i < 8; i++) step(0, 1, '0, 0, 0, 1, "R9 cascade up");
    for (int i = 0; i < 8; i++) step(0, 1, '0, 0, 0, 0, "R9 cascade down");
    // R8 wrap downward
    step(0, 0, 12'h002, 0, 0, 0, "R2 load down");
    for (int i = 0; i < 6; i++) step(0, 1, '0, 0, 0, 0, "R8 down wrap");
    // R7 direction change at zero with no count
    step(0, 0, 12'h000, 1, 0, 1, "R2 load zero");
    step(0, 1, '0, 1, 0, 0, "R7 dir down at zero");
    step(0, 1, '0, 1, 0, 1, "R7 dir up at zero");
    step(0, 1, '0, 1, 1, 0, "R6 ent blocks carry");
    // R6 enp has no effect on carry at all ones
    step(0, 0, 12'hFFF, 1, 0, 1, "R2 load ones");
    step(0, 1, '0, 1, 0, 1, "R6 enp high at ones");
    step(0, 1, '0, 1, 0, 0, "R7 dir down at ones");
    step(0, 1, '0, 0, 0, 1, "R8 wrap ones");
    // Long mixed run
    for (int i = 0; i < 300; i++) step(0, 1, '0, 0, 0, 1, "R3 R9 long up");
    for (int i = 0; i < 310; i++) step(0, 1, '0, (i % 7) == 3, 0, 0, "R4 R5 long down");
    step(0, 1, '0, 1, 1, 1, "R5 final hold");
    repeat (3) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule